// File: doc/BRIEF.md
# Branch and Condition-Code Unit

This unit holds the four arithmetic flags of a 16-bit processor: negative, zero, overflow and carry. It executes three groups of instructions. The first is the conditional branches, which cover signed and unsigned comparisons. The second is a loop instruction that decrements a register and branches backwards. The third is a family of opcodes that set or clear any subset of the flags.

Each cycle the surrounding pipeline may present one instruction word with a valid strobe. With it come the program counter, which already points past the instruction, and the contents of the register named by the loop instruction. One clock edge later the unit presents the result. This is the next program counter, a taken indication, the decremented register value with its index and write strobe, and the flags after the instruction.

Instruction words outside the three groups pass through with no effect. For those the next program counter equals the incoming one.

Top module: `bcc_unit`

## Requirements
- R1: While `rstN` is low, all four flags, `resValid`, `taken` and `regWrite` are 0.
- R2: Results appear on the clock edge that samples `instValid` high, with `resValid` high for that one cycle. An instruction presented with `instValid` low changes neither the flags nor any strobe.
- R3: A taken branch gives `pcNext = pcIn + 2*off`, where `off` is bits 7..0 read as a signed value (-128..127). An untaken branch gives `pcNext = pcIn`.
- R4: Branches that test single flags have these taken conditions, listed by high byte in hex:
  - 0x01: always.
  - 0x02: Z=0. 0x03: Z=1.
  - 0x80: N=0. 0x81: N=1.
  - 0x84: V=0. 0x85: V=1.
  - 0x86: C=0. 0x87: C=1.
- R5: Signed branches have these taken conditions:
  - 0x04: (N xor V)=0. 0x05: (N xor V)=1.
  - 0x06: (Z or (N xor V))=0. 0x07: (Z or (N xor V))=1.
- R6: Unsigned branches have these taken conditions: 0x82 when (C or Z)=0, and 0x83 when (C or Z)=1.
- R7: A branch leaves the flags unchanged and keeps `regWrite` low.
- R8: The loop instruction has bits 15..9 = 0111111, a register index in bits 8..6 and an unsigned count in bits 5..0. It writes `regOut = regIn - 1` with `regSel` = index and `regWrite` high. It is taken exactly when that result is nonzero, and then `pcNext = pcIn - 2*count`; otherwise `pcNext = pcIn`.
- R9: The flag opcodes have bits 15..5 = 00000000101. Bits 3, 2, 1 and 0 select N, Z, V and C. Bit 4 chooses whether the selected flags are set (1) or cleared (0). Unselected flags keep their value, and the instruction is never taken.
- R10: Any other instruction word gives `taken` 0, `regWrite` 0, `pcNext = pcIn` and unchanged flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 16 | Instruction word |
| pcIn | input | 16 | Program counter past the instruction |
| regIn | input | 16 | Value of the register named by the loop instruction |
| pcNext | output | 16 | Next program counter |
| taken | output | 1 | Control transfer taken |
| regOut | output | 16 | Value to write back to the register |
| regSel | output | 3 | Index of the register to write |
| regWrite | output | 1 | Write-back strobe |
| resValid | output | 1 | Result outputs are valid |
| flags | output | 4 | Flags {N,Z,V,C} |

## Verification
The bench sweeps every branch opcode against all sixteen flag states, using offsets that include the extremes +127 and -128. A condition with swapped polarity, or an unsigned test wired to the signed flags, would show up as a wrong taken bit in some flag state. An offset that is not sign-extended, or not scaled by two, would give a wrong target for the negative or large offsets.

The loop instruction is run with register values 0, 1 and 0x8000. These catch a design that tests the value before the decrement, or one that misses the wrap from 0 to 0xFFFF. The count is applied at 0 and at 63, which catches a count wrongly treated as signed.

All 32 flag opcodes are applied from every starting flag state. A design that touches flags outside the mask, or reverses the set and clear choice, would leave the wrong flags.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int WORD_W = 16;
  localparam int OFFS_W = 8;
  localparam int CNT_W  = 6;
  localparam int IDX_W  = 3;
  localparam int FLAG_W = 4;
  localparam int N_BIT  = 3;
  localparam int Z_BIT  = 2;
  localparam int V_BIT  = 1;
  localparam int C_BIT  = 0;

  typedef struct packed {
    logic              isBranch;
    logic              condMet;
    logic              isLoop;
    logic              isCc;
    logic              ccSet;
    logic [FLAG_W-1:0] ccMask;
  } ctlStrobes_t;
endpackage

// File: rtl/bcc_ctl.sv
module bcc_ctl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic [FLAG_W-1:0] flags,
  output ctlStrobes_t       strobes
);
  logic brGroup, loopOp, ccOp, oddCond, nF, zF, vF, cF;

  always_comb begin
    nF = flags[N_BIT];
    zF = flags[Z_BIT];
    vF = flags[V_BIT];
    cF = flags[C_BIT];
    brGroup = (instWord[14:11] == 4'b0000) &&
              (instWord[15] || (instWord[10:8] != 3'b000));
    loopOp  = (instWord[15:9] == 7'b0111111);
    ccOp    = (instWord[15:5] == 11'b00000000101);
    // condition of the odd code in each pair; the even code is its inverse
    unique case ({instWord[15], instWord[10:9]})
      3'b000:  oddCond = 1'b1;
      3'b001:  oddCond = zF;
      3'b010:  oddCond = nF ^ vF;
      3'b011:  oddCond = zF | (nF ^ vF);
      3'b100:  oddCond = nF;
      3'b101:  oddCond = cF | zF;
      3'b110:  oddCond = vF;
      default: oddCond = cF;
    endcase
    strobes.isBranch = instValid && brGroup;
    strobes.condMet  = instWord[8] ? oddCond : !oddCond;
    strobes.isLoop   = instValid && loopOp;
    strobes.isCc     = instValid && ccOp;
    strobes.ccSet    = instWord[4];
    strobes.ccMask   = instWord[3:0];
  end

  // R10
  decode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.isBranch, strobes.isLoop, strobes.isCc}));

  // R2
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !(strobes.isBranch || strobes.isLoop || strobes.isCc));
endmodule

// File: rtl/bcc_dp.sv
module bcc_dp
  import bcc_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  ctlStrobes_t       strobes,
  input  logic [15:0]       instWord,
  input  logic [WIDTH-1:0]  pcIn,
  input  logic [WIDTH-1:0]  regIn,
  output logic [WIDTH-1:0]  pcNext,
  output logic              taken,
  output logic [WIDTH-1:0]  regOut,
  output logic [IDX_W-1:0]  regSel,
  output logic              regWrite,
  output logic              resValid,
  output logic [FLAG_W-1:0] flags
);
  localparam int BR_EXT = WIDTH - OFFS_W - 1;
  localparam int LP_EXT = WIDTH - CNT_W - 1;

  logic [WIDTH-1:0] brDist, loopDist, decVal;

  always_comb begin
    brDist   = {{BR_EXT{instWord[OFFS_W-1]}}, instWord[OFFS_W-1:0], 1'b0};
    loopDist = {{LP_EXT{1'b0}}, instWord[CNT_W-1:0], 1'b0};
    decVal   = regIn - WIDTH'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      resValid <= 1'b0;
      taken    <= 1'b0;
      regWrite <= 1'b0;
      pcNext   <= '0;
      regOut   <= '0;
      regSel   <= '0;
    end else begin
      resValid <= instValid;
      taken    <= 1'b0;
      regWrite <= 1'b0;
      if (instValid) begin
        pcNext <= pcIn;
        regOut <= regIn;
        regSel <= instWord[8:6];
        if (strobes.isBranch && strobes.condMet) begin
          taken  <= 1'b1;
          pcNext <= pcIn + brDist;
        end
        if (strobes.isLoop) begin
          regWrite <= 1'b1;
          regOut   <= decVal;
          if (decVal != '0) begin
            taken  <= 1'b1;
            pcNext <= pcIn - loopDist;
          end
        end
        if (strobes.isCc)
          flags <= strobes.ccSet ? (flags | strobes.ccMask)
                                 : (flags & ~strobes.ccMask);
      end
    end
  end

  // R7
  branch_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.isBranch |=> $stable(flags) && !regWrite);

  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !resValid && !taken && !regWrite && $stable(flags));

  // R8
  loop_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && regWrite) |-> (taken == (regOut != '0)));

  // R3
  pc_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> pcNext[0] == $past(pcIn[0]));

  // R9
  cc_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.isCc && strobes.ccMask == '0) |=> $stable(flags) && !taken);

  // R10
  other_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !strobes.isBranch && !strobes.isLoop && !strobes.isCc)
      |=> !taken && !regWrite && $stable(flags));
endmodule

// File: rtl/bcc_unit.sv
module bcc_unit
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [15:0]       instWord,
  input  logic [15:0]       pcIn,
  input  logic [15:0]       regIn,
  output logic [15:0]       pcNext,
  output logic              taken,
  output logic [15:0]       regOut,
  output logic [2:0]        regSel,
  output logic              regWrite,
  output logic              resValid,
  output logic [3:0]        flags
);
  ctlStrobes_t strobes;

  bcc_ctl ctl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .flags(flags), .strobes(strobes)
  );

  bcc_dp #(.WIDTH(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .strobes(strobes),
    .instWord(instWord), .pcIn(pcIn), .regIn(regIn), .pcNext(pcNext),
    .taken(taken), .regOut(regOut), .regSel(regSel), .regWrite(regWrite),
    .resValid(resValid), .flags(flags)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (flags == 4'b0) && !resValid && !taken && !regWrite);
endmodule

// File: tb/bcc_unit_tb_top.sv
module bcc_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [15:0] instWord = '0, pcIn = '0, regIn = '0;
  logic [15:0] pcNext, regOut;
  logic taken, regWrite, resValid;
  logic [2:0] regSel;
  logic [3:0] flags;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bcc_unit dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .pcIn(pcIn), .regIn(regIn), .pcNext(pcNext), .taken(taken),
    .regOut(regOut), .regSel(regSel), .regWrite(regWrite),
    .resValid(resValid), .flags(flags)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runInst(input logic [15:0] iw, input logic [15:0] pc, input logic [15:0] rv);
    @(negedge clk);
    instWord = iw; pcIn = pc; regIn = rv; instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic setFlags(input logic [3:0] f);
    runInst(16'o000257, 16'h0100, 16'h0);
    runInst(16'o000260 | {12'h0, f}, 16'h0100, 16'h0);
  endtask

  // expected branch condition from R4, R5, R6; f = {N,Z,V,C}
  function automatic logic expCond(input logic [7:0] hb, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (hb)
      8'h01: return 1'b1;             // R4 always
      8'h02: return !z;               // R4
      8'h03: return z;                // R4
      8'h04: return !(n ^ v);         // R5
      8'h05: return n ^ v;            // R5
      8'h06: return !(z | (n ^ v));   // R5
      8'h07: return z | (n ^ v);      // R5
      8'h80: return !n;               // R4
      8'h81: return n;                // R4
      8'h82: return !(c | z);         // R6
      8'h83: return c | z;            // R6
      8'h84: return !v;               // R4
      8'h85: return v;                // R4
      8'h86: return !c;               // R4
      default: return c;              // R4 0x87
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] offs [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55};
    logic [15:0] loopRegs [5] = '{16'h0000, 16'h0001, 16'h0002, 16'h8000, 16'hFFFF};
    logic [5:0] cnts [4] = '{6'd0, 6'd1, 6'd37, 6'd63};

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", {12'h0, flags}, 16'h0);
    check("R1 strobes", {13'h0, resValid, taken, regWrite}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 invalid strobe: a set-all opcode with valid low has no effect
    @(negedge clk);
    instWord = 16'o000277; instValid = 1'b0;
    @(negedge clk);
    check("R2 flags idle", {12'h0, flags}, 16'h0);
    check("R2 resValid idle", {15'h0, resValid}, 16'h0);
    runInst(16'o000277, 16'h0200, 16'h0);
    check("R2 resValid", {15'h0, resValid}, 16'h1);
    check("R9 set all", {12'h0, flags}, 16'hF);
    @(negedge clk);
    check("R2 resValid single", {15'h0, resValid}, 16'h0);

    // R3 R4 R5 R6 R7 branch sweep
    for (int f = 0; f < 16; f++) begin
      setFlags(4'(f));
      check("R9 flag load", {12'h0, flags}, 16'(f));
      for (int bt = 1; bt < 16; bt++) begin
        for (int k = 0; k < 6; k++) begin
          logic [7:0] hb;
          logic [15:0] pc, expPc, sOff;
          logic expT;
          hb = {bt[3], 4'b0000, bt[2:0]};
          pc = 16'h4000 + 16'(bt * 6 + k) * 16'd2;
          sOff = {{8{offs[k][7]}}, offs[k]};
          expT = expCond(hb, 4'(f));
          expPc = expT ? pc + (sOff << 1) : pc;
          runInst({hb, offs[k]}, pc, 16'h1234);
          check("R4 R5 R6 taken", {15'h0, taken}, {15'h0, expT});
          check("R3 pcNext", pcNext, expPc);
          check("R7 flags", {12'h0, flags}, 16'(f));
          check("R7 regWrite", {15'h0, regWrite}, 16'h0);
        end
      end
    end

    // R8 loop instruction
    setFlags(4'b1010);
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] pc, expReg, expPc;
        logic [2:0] idx;
        idx = 3'((r + k) % 8);
        pc = 16'h2000;
        expReg = loopRegs[r] - 16'd1;
        expPc = (expReg != 0) ? pc - {9'h0, cnts[k], 1'b0} : pc;
        runInst({7'b0111111, idx, cnts[k]}, pc, loopRegs[r]);
        check("R8 regOut", regOut, expReg);
        check("R8 regSel", {13'h0, regSel}, {13'h0, idx});
        check("R8 regWrite", {15'h0, regWrite}, 16'h1);
        check("R8 taken", {15'h0, taken}, {15'h0, expReg != 0});
        check("R8 pcNext", pcNext, expPc);
      end
    end

    // R9 all flag opcodes from every flag state
    for (int f = 0; f < 16; f++) begin
      for (int op = 0; op < 32; op++) begin
        logic [3:0] m, expF;
        setFlags(4'(f));
        m = 4'(op);
        expF = op[4] ? (4'(f) | m) : (4'(f) & ~m);
        runInst(16'o000240 | 16'(op), 16'h0300, 16'h0);
        check("R9 flags", {12'h0, flags}, {12'h0, expF});
        check("R9 not taken", {15'h0, taken}, 16'h0);
      end
    end

    // R10 other instructions
    setFlags(4'b0110);
    begin
      logic [15:0] others [5] = '{16'h0000, 16'o004067, 16'hFFFF, 16'o000300, 16'o000237};
      for (int i = 0; i < 5; i++) begin
        runInst(others[i], 16'h5550, 16'hABCD);
        check("R10 taken", {15'h0, taken}, 16'h0);
        check("R10 regWrite", {15'h0, regWrite}, 16'h0);
        check("R10 pcNext", pcNext, 16'h5550);
        check("R10 flags", {12'h0, flags}, 16'h6);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule